// File: doc/BRIEF.md
# Incremental PID Motor Position Controller

This block closes a position loop around a DC motor driven through an H-bridge. Each time the sample strobe is raised, it compares a target position with the measured position from an external quadrature counter. It forms an error as a direction flag plus an unsigned distance and runs one incremental PID step on that distance. The step is computed by a small sequencer that does one arithmetic term per state. The new output is the old output plus a correction, limited to the range 0 to `OUT_MAX`, so a large setpoint step cannot wind the integrator up.

The limited output is used as a PWM duty. A free-running ramp counter of `OUT_MAX` cycles is compared against it, and a new duty is only taken up when the ramp wraps to zero. The direction flag steers the PWM to the forward or the reverse bridge input. Two distance thresholds form a hysteresis band around the target, so the motor stops close to the target and does not chatter. Positions are in encoder counts; one shaft revolution is 8384 counts, which fits easily in the default 24-bit position width.

Top module: `pid_motor_ctrl`

## Requirements
- R1: The error distance is |setpoint − feedback| and is taken by two's complement when feedback exceeds setpoint. The direction flag is set exactly when feedback > setpoint, with both values treated as unsigned.
- R2: Each accepted update sets m(k) = m(k−1) + Kp·(e(k) − e(k−1)) + Ki·e(k) + Kd·(e(k) − 2e(k−1) + e(k−2)), where e is the error distance and the gains are unsigned. The history then shifts so that e(k−1) takes e(k) and e(k−2) takes e(k−1).
- R3: A strobe is accepted only while the sequencer is idle. An accepted strobe latches setpoint and feedback, and the result is written five clock edges later. Strobes that arrive during those five edges are ignored.
- R4: Before it is stored, the update result is limited to the range 0 to `OUT_MAX`, so it never goes below 0 and never above `OUT_MAX`.
- R5: The PWM period is `OUT_MAX` clocks. In each period the active drive output is high for exactly duty clocks: a duty of 0 keeps it low, and a duty of `OUT_MAX` keeps it high.
- R6: A new duty takes effect only at the start of the next PWM period. The period that is running when the update lands keeps the old duty.
- R7: The forward output carries the PWM when the stored direction is forward (setpoint above feedback). The reverse output carries it when the stored direction is reverse (feedback above setpoint). The two outputs are never high together.
- R8: At each update, the drive is handled by the error distance:
  - At or below `HOLD_BAND`, the drive stops and both outputs stay low.
  - Above `RESUME_BAND`, the drive takes the direction of the new error.
  - In between, the previous state (stopped, forward or reverse) is kept.
- R9: After reset both outputs are low. The stored output and both error history values are zero, and the drive is stopped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sample | input | 1 | Starts one control update when the sequencer is idle |
| setpoint | input | POS_W | Target position in encoder counts |
| feedback | input | POS_W | Measured position in encoder counts |
| kp | input | GAIN_W | Proportional gain |
| ki | input | GAIN_W | Integral gain |
| kd | input | GAIN_W | Derivative gain |
| drive_fwd | output | 1 | PWM to the forward bridge input |
| drive_rev | output | 1 | PWM to the reverse bridge input |

## Verification
The bench builds the block with 8-bit positions, 4-bit gains, `OUT_MAX` = 20, `HOLD_BAND` = 2 and `RESUME_BAND` = 5. With a 20-clock PWM period, the duty can be measured directly by counting high cycles, and both limits of the output range are hit quickly. The small widths allow the following:
- a full sweep of feedback across ±19 counts around the setpoint;
- a check of the unsigned comparison at the far ends of the position range;
- a grid of gain combinations, all checked against an arithmetic model of the update law, the limiting and the hysteresis.

Counting high cycles over whole, period-aligned windows shows the point at which a new duty is taken up.

// File: rtl/pid_motor_pkg.sv
package pid_motor_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_PROP  = 3'd1,
        ST_INTEG = 3'd2,
        ST_DERIV = 3'd3,
        ST_SUM   = 3'd4,
        ST_CLAMP = 3'd5
    } upd_state_t;

    typedef enum logic [1:0] {
        DIR_STOP = 2'd0,
        DIR_FWD  = 2'd1,
        DIR_REV  = 2'd2
    } drive_dir_t;

    typedef struct packed {
        logic sgn;
        logic fresh;
    } err_flags_t;

endpackage

// File: rtl/pid_err_calc.sv
module pid_err_calc #(
    parameter int POS_W = 24
) (
    input  logic [POS_W-1:0] setpoint_i,
    input  logic [POS_W-1:0] feedback_i,
    output logic             neg_o,
    output logic [POS_W-1:0] mag_o
);

    logic [POS_W-1:0] diff_w;

    always_comb begin
        diff_w = setpoint_i - feedback_i;
        neg_o  = (feedback_i > setpoint_i);
        mag_o  = neg_o ? (~diff_w + 1'b1) : diff_w;
    end

endmodule

// File: rtl/pid_update.sv
module pid_update
    import pid_motor_pkg::*;
#(
    parameter int POS_W   = 24,
    parameter int GAIN_W  = 8,
    parameter int OUT_MAX = 64000,
    parameter int DUTY_W  = $clog2(OUT_MAX + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sample_i,
    input  logic              neg_i,
    input  logic [POS_W-1:0]  mag_i,
    input  logic [GAIN_W-1:0] kp_i,
    input  logic [GAIN_W-1:0] ki_i,
    input  logic [GAIN_W-1:0] kd_i,
    output logic [DUTY_W-1:0] duty_o,
    output logic              upd_o,
    output logic              neg_o,
    output logic [POS_W-1:0]  mag_o
);

    localparam int DIFF_W = POS_W + 3;
    localparam int PROD_W = DIFF_W + GAIN_W + 1;
    localparam int ACC_W  = PROD_W + DUTY_W + 3;
    localparam logic signed [ACC_W-1:0] ACC_MAX = ACC_W'(OUT_MAX);
    localparam logic [DUTY_W-1:0]       DUTY_MAX = DUTY_W'(OUT_MAX);

    upd_state_t               state_q;
    err_flags_t               flags_q;
    logic [POS_W-1:0]         e_k, e_k1, e_k2;
    logic signed [PROD_W-1:0] term_p, term_i, term_d;
    logic signed [ACC_W-1:0]  acc_q;
    logic [DUTY_W-1:0]        m_q, m_lim;

    logic signed [DIFF_W-1:0] ek_s, ek1_s, ek2_s, dp_s, dd_s;
    logic signed [GAIN_W:0]   kp_s, ki_s, kd_s;

    assign ek_s  = $signed({{(DIFF_W-POS_W){1'b0}}, e_k});
    assign ek1_s = $signed({{(DIFF_W-POS_W){1'b0}}, e_k1});
    assign ek2_s = $signed({{(DIFF_W-POS_W){1'b0}}, e_k2});
    assign dp_s  = ek_s - ek1_s;
    assign dd_s  = ek_s - (ek1_s <<< 1) + ek2_s;
    assign kp_s  = $signed({1'b0, kp_i});
    assign ki_s  = $signed({1'b0, ki_i});
    assign kd_s  = $signed({1'b0, kd_i});

    always_comb begin
        if (acc_q[ACC_W-1])
            m_lim = '0;
        else if (acc_q > ACC_MAX)
            m_lim = DUTY_MAX;
        else
            m_lim = acc_q[DUTY_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            flags_q <= '0;
            e_k     <= '0;
            e_k1    <= '0;
            e_k2    <= '0;
            term_p  <= '0;
            term_i  <= '0;
            term_d  <= '0;
            acc_q   <= '0;
            m_q     <= '0;
        end else begin
            flags_q.fresh <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (sample_i) begin
                        e_k         <= mag_i;
                        flags_q.sgn <= neg_i;
                        state_q     <= ST_PROP;
                    end
                end
                ST_PROP: begin
                    term_p  <= PROD_W'(dp_s) * PROD_W'(kp_s);
                    state_q <= ST_INTEG;
                end
                ST_INTEG: begin
                    term_i  <= PROD_W'(ek_s) * PROD_W'(ki_s);
                    state_q <= ST_DERIV;
                end
                ST_DERIV: begin
                    term_d  <= PROD_W'(dd_s) * PROD_W'(kd_s);
                    state_q <= ST_SUM;
                end
                ST_SUM: begin
                    acc_q   <= ACC_W'($signed({1'b0, m_q})) + ACC_W'(term_p)
                             + ACC_W'(term_i) + ACC_W'(term_d);
                    state_q <= ST_CLAMP;
                end
                ST_CLAMP: begin
                    m_q           <= m_lim;
                    e_k1          <= e_k;
                    e_k2          <= e_k1;
                    flags_q.fresh <= 1'b1;
                    state_q       <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign duty_o = m_q;
    assign upd_o  = (state_q == ST_CLAMP);
    assign neg_o  = flags_q.sgn;
    assign mag_o  = e_k;

    p_duty_cap_r4: assert property (@(posedge clk) disable iff (rst)
        m_q <= DUTY_MAX);

    p_hold_unless_final_r3: assert property (@(posedge clk) disable iff (rst)
        (state_q != ST_CLAMP) |=> $stable(m_q));

    p_history_shift_r2: assert property (@(posedge clk) disable iff (rst)
        flags_q.fresh |-> (e_k1 == e_k));

endmodule

// File: rtl/pid_pwm_gen.sv
module pid_pwm_gen #(
    parameter int OUT_MAX = 64000,
    parameter int DUTY_W  = $clog2(OUT_MAX + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DUTY_W-1:0] duty_i,
    output logic              pwm_o
);

    localparam logic [DUTY_W-1:0] LAST     = DUTY_W'(OUT_MAX - 1);
    localparam logic [DUTY_W-1:0] DUTY_MAX = DUTY_W'(OUT_MAX);

    logic [DUTY_W-1:0] cnt_q;
    logic [DUTY_W-1:0] duty_lat;
    logic              pwm_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q    <= '0;
            duty_lat <= '0;
            pwm_q    <= 1'b0;
        end else begin
            pwm_q <= (cnt_q < duty_lat);
            if (cnt_q == LAST) begin
                cnt_q    <= '0;
                duty_lat <= duty_i;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assign pwm_o = pwm_q;

    p_latch_at_wrap_r6: assert property (@(posedge clk) disable iff (rst)
        !$stable(duty_lat) |-> (cnt_q == '0));

    p_full_on_r5: assert property (@(posedge clk) disable iff (rst)
        (duty_lat == DUTY_MAX) |=> pwm_q);

    p_zero_off_r5: assert property (@(posedge clk) disable iff (rst)
        (duty_lat == '0) |=> !pwm_q);

endmodule

// File: rtl/pid_dir_select.sv
module pid_dir_select
    import pid_motor_pkg::*;
#(
    parameter int POS_W       = 24,
    parameter int HOLD_BAND   = 8,
    parameter int RESUME_BAND = 24
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             upd_i,
    input  logic             neg_i,
    input  logic [POS_W-1:0] mag_i,
    input  logic             pwm_i,
    output logic             drive_fwd_o,
    output logic             drive_rev_o
);

    localparam logic [POS_W-1:0] HOLD_M   = POS_W'(HOLD_BAND);
    localparam logic [POS_W-1:0] RESUME_M = POS_W'(RESUME_BAND);

    drive_dir_t dir_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            dir_q <= DIR_STOP;
        end else if (upd_i) begin
            if (mag_i <= HOLD_M)
                dir_q <= DIR_STOP;
            else if (mag_i > RESUME_M)
                dir_q <= neg_i ? DIR_REV : DIR_FWD;
        end
    end

    assign drive_fwd_o = pwm_i && (dir_q == DIR_FWD);
    assign drive_rev_o = pwm_i && (dir_q == DIR_REV);

    p_band_stop_r8: assert property (@(posedge clk) disable iff (rst)
        (upd_i && (mag_i <= HOLD_M)) |=> (dir_q == DIR_STOP));

    p_resume_dir_r7: assert property (@(posedge clk) disable iff (rst)
        (upd_i && (mag_i > RESUME_M)) |=> (dir_q == ($past(neg_i) ? DIR_REV : DIR_FWD)));

    p_between_keep_r8: assert property (@(posedge clk) disable iff (rst)
        (upd_i && (mag_i > HOLD_M) && (mag_i <= RESUME_M)) |=> $stable(dir_q));

endmodule

// File: rtl/pid_motor_ctrl.sv
module pid_motor_ctrl #(
    parameter int POS_W       = 24,
    parameter int GAIN_W      = 8,
    parameter int OUT_MAX     = 64000,
    parameter int HOLD_BAND   = 8,
    parameter int RESUME_BAND = 24
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sample,
    input  logic [POS_W-1:0]  setpoint,
    input  logic [POS_W-1:0]  feedback,
    input  logic [GAIN_W-1:0] kp,
    input  logic [GAIN_W-1:0] ki,
    input  logic [GAIN_W-1:0] kd,
    output logic              drive_fwd,
    output logic              drive_rev
);

    localparam int DUTY_W = $clog2(OUT_MAX + 1);

    logic              neg_w;
    logic [POS_W-1:0]  mag_w;
    logic [DUTY_W-1:0] duty_w;
    logic              upd_w;
    logic              neg_lat;
    logic [POS_W-1:0]  mag_lat;
    logic              pwm_w;

    pid_err_calc #(.POS_W(POS_W)) u_err (
        .setpoint_i (setpoint),
        .feedback_i (feedback),
        .neg_o      (neg_w),
        .mag_o      (mag_w)
    );

    pid_update #(
        .POS_W   (POS_W),
        .GAIN_W  (GAIN_W),
        .OUT_MAX (OUT_MAX),
        .DUTY_W  (DUTY_W)
    ) u_upd (
        .clk      (clk),
        .rst      (rst),
        .sample_i (sample),
        .neg_i    (neg_w),
        .mag_i    (mag_w),
        .kp_i     (kp),
        .ki_i     (ki),
        .kd_i     (kd),
        .duty_o   (duty_w),
        .upd_o    (upd_w),
        .neg_o    (neg_lat),
        .mag_o    (mag_lat)
    );

    pid_pwm_gen #(
        .OUT_MAX (OUT_MAX),
        .DUTY_W  (DUTY_W)
    ) u_pwm (
        .clk    (clk),
        .rst    (rst),
        .duty_i (duty_w),
        .pwm_o  (pwm_w)
    );

    pid_dir_select #(
        .POS_W       (POS_W),
        .HOLD_BAND   (HOLD_BAND),
        .RESUME_BAND (RESUME_BAND)
    ) u_dir (
        .clk         (clk),
        .rst         (rst),
        .upd_i       (upd_w),
        .neg_i       (neg_lat),
        .mag_i       (mag_lat),
        .pwm_i       (pwm_w),
        .drive_fwd_o (drive_fwd),
        .drive_rev_o (drive_rev)
    );

    p_sign_r1: assert property (@(posedge clk) disable iff (rst)
        neg_w |-> (feedback > setpoint));

    p_mag_r1: assert property (@(posedge clk) disable iff (rst)
        neg_w |-> (mag_w == POS_W'(feedback - setpoint)));

    p_never_both_r7: assert property (@(posedge clk) disable iff (rst)
        !(drive_fwd && drive_rev));

endmodule

// File: tb/pid_motor_ctrl_test.sv
`timescale 1ns/1ps
module pid_motor_ctrl_test;

    localparam int PW   = 8;
    localparam int GW   = 4;
    localparam int N    = 20;
    localparam int HOLD = 2;
    localparam int RES  = 5;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          sample = 1'b0;
    logic [PW-1:0] setpoint = '0;
    logic [PW-1:0] feedback = '0;
    logic [GW-1:0] kp = '0, ki = '0, kd = '0;
    logic          drive_fwd, drive_rev;

    int checks = 0;
    int failures = 0;
    int cyc = 0;

    int m_m, m_e1, m_e2, m_dir;

    always #2 clk = ~clk;

    always @(posedge clk) begin
        if (rst) cyc <= 0;
        else     cyc <= cyc + 1;
    end

    pid_motor_ctrl #(
        .POS_W(PW), .GAIN_W(GW), .OUT_MAX(N), .HOLD_BAND(HOLD), .RESUME_BAND(RES)
    ) uut (
        .clk(clk), .rst(rst), .sample(sample), .setpoint(setpoint),
        .feedback(feedback), .kp(kp), .ki(ki), .kd(kd),
        .drive_fwd(drive_fwd), .drive_rev(drive_rev)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic model_step(input int sp, input int fb);
        int e, acc;
        e = (sp >= fb) ? sp - fb : fb - sp;
        acc = m_m + int'(kp) * (e - m_e1) + int'(ki) * e + int'(kd) * (e - 2 * m_e1 + m_e2);
        if (acc < 0) acc = 0;
        if (acc > N) acc = N;
        m_m = acc;
        m_e2 = m_e1;
        m_e1 = e;
        if (e <= HOLD)     m_dir = 0;
        else if (e > RES)  m_dir = (fb > sp) ? 2 : 1;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        sample = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        m_m = 0; m_e1 = 0; m_e2 = 0; m_dir = 0;
    endtask

    task automatic do_sample(input int sp, input int fb);
        @(negedge clk);
        setpoint = PW'(sp);
        feedback = PW'(fb);
        sample = 1'b1;
        @(negedge clk);
        sample = 1'b0;
        model_step(sp, fb);
        repeat (8) @(negedge clk);
    endtask

    task automatic measure(input string req);
        int cf, cr;
        repeat (2 * N + 4) @(negedge clk);
        cf = 0; cr = 0;
        repeat (N) begin
            @(negedge clk);
            cf += int'(drive_fwd);
            cr += int'(drive_rev);
        end
        chk({req, " fwd"}, cf, (m_dir == 1) ? m_m : 0);
        chk({req, " rev"}, cr, (m_dir == 2) ? m_m : 0);
    endtask

    initial begin
        int cf, cr;
        // R9: reset state
        repeat (2) @(negedge clk);
        chk("R9 fwd in reset", int'(drive_fwd), 0);
        chk("R9 rev in reset", int'(drive_rev), 0);
        do_reset();
        measure("R9 idle after reset");

        // R1 R7 R8: sweep of feedback around setpoint from reset, kp=1
        kp = 1; ki = 0; kd = 0;
        for (int d = -19; d <= 19; d++) begin
            do_reset();
            do_sample(100, 100 + d);
            measure("R1 R7 sweep");
        end

        // R1: unsigned compare at the ends of the range
        do_reset();
        kp = 0; ki = 1; kd = 0;
        do_sample(3, 250);
        measure("R1 wide reverse");
        do_reset();
        do_sample(250, 3);
        measure("R1 wide forward");

        // R2 R4 R5: gain grid against the model
        for (int a = 0; a < 3; a++) begin
            for (int b = 0; b < 2; b++) begin
                for (int c = 0; c < 3; c++) begin
                    do_reset();
                    kp = GW'(a); ki = GW'(b); kd = GW'(2 * c);
                    do_sample(100, 92);  measure("R2 grid");
                    do_sample(100, 95);  measure("R2 grid");
                    do_sample(100, 98);  measure("R4 grid");
                    do_sample(100, 99);  measure("R4 grid");
                    do_sample(100, 103); measure("R5 grid");
                    do_sample(100, 108); measure("R5 grid");
                end
            end
        end

        // R8: hysteresis hold and release
        do_reset();
        kp = 1; ki = 0; kd = 0;
        do_sample(100, 90);  measure("R8 drive fwd");
        do_sample(100, 96);  measure("R8 keep fwd in band");
        do_sample(100, 99);  measure("R8 stop near target");
        do_sample(100, 96);  measure("R8 stay stopped in band");
        do_sample(100, 108); measure("R8 resume reverse");

        // R3: strobes during computation are ignored
        do_reset();
        kp = 1; ki = 0; kd = 0;
        @(negedge clk);
        setpoint = 8'd100; feedback = 8'd90; sample = 1'b1;
        @(negedge clk);
        feedback = 8'd80;
        repeat (3) @(negedge clk);
        sample = 1'b0;
        model_step(100, 90);
        repeat (8) @(negedge clk);
        measure("R3 busy strobe ignored");

        // R6: duty change lands mid-period, taken up at next period
        do_reset();
        kp = 1; ki = 0; kd = 0;
        do_sample(100, 90);
        measure("R6 settle");
        while ((cyc % N) != 0) @(negedge clk);
        cf = 0;
        for (int i = 0; i < N; i++) begin
            if (i == 3) begin
                feedback = 8'd85;
                sample = 1'b1;
            end else begin
                sample = 1'b0;
            end
            @(negedge clk);
            cf += int'(drive_fwd);
        end
        sample = 1'b0;
        chk("R6 running period keeps old duty", cf, 10);
        cf = 0; cr = 0;
        for (int i = 0; i < N; i++) begin
            @(negedge clk);
            cf += int'(drive_fwd);
            cr += int'(drive_rev);
        end
        chk("R6 next period new duty", cf, 15);
        chk("R7 reverse idle", cr, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(4 * 200000);
        checks++;
        failures++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule